// File: doc/BRIEF.md
# Machine-Mode Trap Controller

This block holds the machine-level trap state of a small in-order core. It decides, cycle by cycle, whether the current instruction should be diverted into a handler. A diversion happens for a synchronous fault reported by the pipeline, or for one of three asynchronous interrupt classes: software, timer and external. All four causes go through the same entry path. On entry the block saves the faulting or interrupted PC and the cause. It clears the global enable, pushes the previous enable and previous privilege into the status register, and steers fetch to the handler base address.

The pipeline also reports a return-from-trap instruction. The block then pops the saved enable and privilege and steers fetch back to the saved PC. A single-cycle read/write port gives software access to the six registers. Writes take effect at the next clock edge. Reads are combinational. The redirect outputs are combinational in the same cycle as the request. Only direct vectoring is provided: every trap enters at one base address.

Top module: `mtrap_ctrl`

## Requirements
- R1: After reset the privilege output is 3 (machine). Status, enable, cause, saved PC and vector all read 0. A read of an unmapped address returns 0.
- R2: When `exc_req` is high, `redir_valid` is high in the same cycle and `redir_pc` equals the vector base. After the clock edge, the saved-PC register (0x341) holds `cur_pc` and the cause register (0x342) holds `exc_code` with bit 31 clear.
- R3: On any trap entry, the status register (0x300) is updated as follows: bit 7 (prior enable) takes the old value of bit 3, and bit 3 (global enable) becomes 0. Bits 12:11 (prior privilege) take the current privilege, and the privilege output becomes 3.
- R4: An interrupt class is taken only when three bits are all set: its pending bit, its enable bit in register 0x304, and status bit 3. Each class uses the same bit position in 0x304 and 0x344: software is bit 3, timer bit 7 and external bit 11. The cause written is bit 31 set with code 3, 7 or 11 respectively.
- R5: When several enabled interrupts are pending together, external is taken before software, and software before timer.
- R6: A synchronous exception is taken even when interrupts are globally disabled. When an exception and an enabled interrupt arrive in the same cycle, the exception is taken.
- R7: `mret_req` without a trap in the same cycle redirects to the saved PC. At the edge, status bit 3 takes bit 7, bit 7 becomes 1, the privilege output takes bits 12:11, and bits 12:11 become 0.
- R8: The pending register (0x344) reflects the three interrupt lines in the same cycle. Writes to it have no effect.
- R9: The vector register (0x305) always reads with bits 1:0 zero, and the handler address has bits 1:0 zero.
- R10: A CSR write to status, saved PC or cause in the same cycle as a trap entry is dropped in favour of the trap updates. A status write in the same cycle as a return is dropped in favour of the return updates.
- R11: Software can write and read back the enable, vector, saved-PC, cause and status registers. A status write to bits 12:11 stores 3 for the value 3 and 0 for any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Synchronous exception request from the pipeline |
| exc_code | input | CODE_W | Exception cause code |
| cur_pc | input | XLEN | PC of the instruction in the trap-decision stage |
| mret_req | input | 1 | Return-from-trap instruction executing |
| irq_sw | input | 1 | Software interrupt line |
| irq_tmr | input | 1 | Timer interrupt line |
| irq_ext | input | 1 | External interrupt line |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address for read and write |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data (combinational) |
| redir_valid | output | 1 | Fetch redirect this cycle |
| redir_pc | output | XLEN | Redirect target |
| priv | output | 2 | Current privilege level |

## Verification
The bench targets the cycles in which two things compete. In one, an exception meets an enabled interrupt; a design that got this wrong would record an interrupt cause and lose the fault. In another, a CSR write lands together with a trap or a return; a design with the wrong ordering would let the write overwrite the saved PC or status, so the handler would return to the wrong place. The bench also walks the interrupt gating one enable at a time and checks the pending-line priority order. A wrong priority or a missed global-enable gate shows up directly as the wrong cause code. Round trips into user privilege check that the privilege is pushed and popped rather than being fixed at machine level.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
  localparam int NIRQ = 3;
  // interrupt class index; code and enable/pending bit position = 4*idx+3
  localparam int IX_SW  = 0;
  localparam int IX_TMR = 1;
  localparam int IX_EXT = 2;

  localparam logic [11:0] A_STATUS = 12'h300;
  localparam logic [11:0] A_IE     = 12'h304;
  localparam logic [11:0] A_TVEC   = 12'h305;
  localparam logic [11:0] A_EPC    = 12'h341;
  localparam logic [11:0] A_CAUSE  = 12'h342;
  localparam logic [11:0] A_IP     = 12'h344;

  localparam int ST_GIE  = 3;
  localparam int ST_PIE  = 7;
  localparam int ST_PPLO = 11;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_M = 2'd3;

  function automatic int irq_bitpos(int idx);
    return 4 * idx + 3;
  endfunction

  // fixed priority: external, then software, then timer
  function automatic logic [NIRQ-1:0] irq_pick(logic [NIRQ-1:0] m);
    logic [NIRQ-1:0] s;
    s = '0;
    if (m[IX_EXT])      s[IX_EXT] = 1'b1;
    else if (m[IX_SW])  s[IX_SW]  = 1'b1;
    else if (m[IX_TMR]) s[IX_TMR] = 1'b1;
    return s;
  endfunction

  function automatic logic [1:0] legal_priv(logic [1:0] p);
    return (p == PRIV_M) ? PRIV_M : PRIV_U;
  endfunction
endpackage

// File: rtl/mtrap_irq_arb.sv
module mtrap_irq_arb
  import mtrap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] pend,
  input  logic [NIRQ-1:0] en,
  input  logic            gie,
  output logic            take,
  output logic [3:0]      code,
  output logic [NIRQ-1:0] sel
);
  logic [NIRQ-1:0] masked;

  for (genvar i = 0; i < NIRQ; i++) begin : g_mask
    assign masked[i] = pend[i] & en[i] & gie;
  end

  assign sel  = irq_pick(masked);
  assign take = |sel;

  always_comb begin
    code = '0;
    for (int i = 0; i < NIRQ; i++)
      if (sel[i]) code = 4'(irq_bitpos(i));
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R5
  AST_EXT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (gie && pend[IX_EXT] && en[IX_EXT]) |-> sel[IX_EXT]); // R5
endmodule

// File: rtl/mtrap_csr_regs.sv
module mtrap_csr_regs
  import mtrap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_en,
  input  logic              trap_is_irq,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic              mret_en,
  input  logic              wr_en,
  input  logic [11:0]       addr,
  input  logic [XLEN-1:0]   wr_data,
  input  logic [NIRQ-1:0]   lines,
  output logic [XLEN-1:0]   rd_data,
  output logic [XLEN-1:0]   vec_base,
  output logic [XLEN-1:0]   epc,
  output logic              gie,
  output logic [NIRQ-1:0]   ie,
  output logic [1:0]        priv
);
  logic [XLEN-3:0]   tvec_q;
  logic [XLEN-1:0]   epc_q;
  logic              cause_irq_q;
  logic [CODE_W-1:0] cause_code_q;
  logic              gie_q, pie_q;
  logic [1:0]        pp_q, priv_q;
  logic [NIRQ-1:0]   ie_q;
  logic [XLEN-1:0]   status_rd, ie_rd, ip_rd, cause_rd;

  function automatic logic [XLEN-1:0] spread(logic [NIRQ-1:0] v);
    logic [XLEN-1:0] r;
    r = '0;
    for (int i = 0; i < NIRQ; i++) r[irq_bitpos(i)] = v[i];
    return r;
  endfunction

  function automatic logic [NIRQ-1:0] gather(logic [XLEN-1:0] w);
    logic [NIRQ-1:0] r;
    for (int i = 0; i < NIRQ; i++) r[i] = w[irq_bitpos(i)];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tvec_q <= '0; epc_q <= '0; cause_irq_q <= 1'b0; cause_code_q <= '0;
      gie_q <= 1'b0; pie_q <= 1'b0; pp_q <= PRIV_U; priv_q <= PRIV_M; ie_q <= '0;
    end else begin
      if (wr_en && addr == A_TVEC) tvec_q <= wr_data[XLEN-1:2];
      if (wr_en && addr == A_IE)   ie_q   <= gather(wr_data);
      if (trap_en) begin
        epc_q        <= trap_pc;
        cause_irq_q  <= trap_is_irq;
        cause_code_q <= trap_code;
        pie_q        <= gie_q;
        gie_q        <= 1'b0;
        pp_q         <= priv_q;
        priv_q       <= PRIV_M;
      end else if (mret_en) begin
        gie_q  <= pie_q;
        pie_q  <= 1'b1;
        priv_q <= pp_q;
        pp_q   <= PRIV_U;
      end else if (wr_en) begin
        if (addr == A_EPC) epc_q <= wr_data;
        if (addr == A_CAUSE) begin
          cause_irq_q  <= wr_data[XLEN-1];
          cause_code_q <= wr_data[CODE_W-1:0];
        end
        if (addr == A_STATUS) begin
          gie_q <= wr_data[ST_GIE];
          pie_q <= wr_data[ST_PIE];
          pp_q  <= legal_priv(wr_data[ST_PPLO+1:ST_PPLO]);
        end
      end
      if (wr_en && (trap_en || mret_en) && addr == A_EPC && !trap_en)
        epc_q <= wr_data; // saved PC stays software-writable across a return
    end
  end

  always_comb begin
    status_rd = '0;
    status_rd[ST_GIE] = gie_q;
    status_rd[ST_PIE] = pie_q;
    status_rd[ST_PPLO+1:ST_PPLO] = pp_q;
    ie_rd = spread(ie_q);
    ip_rd = spread(lines);
    cause_rd = '0;
    cause_rd[CODE_W-1:0] = cause_code_q;
    cause_rd[XLEN-1] = cause_irq_q;
    unique case (addr)
      A_STATUS: rd_data = status_rd;
      A_IE:     rd_data = ie_rd;
      A_TVEC:   rd_data = {tvec_q, 2'b00};
      A_EPC:    rd_data = epc_q;
      A_CAUSE:  rd_data = cause_rd;
      A_IP:     rd_data = ip_rd;
      default:  rd_data = '0;
    endcase
  end

  assign vec_base = {tvec_q, 2'b00};
  assign epc      = epc_q;
  assign gie      = gie_q;
  assign ie       = ie_q;
  assign priv     = priv_q;

  AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_en |=> epc_q == $past(trap_pc)); // R2
  AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    trap_en |=> !gie_q && pie_q == $past(gie_q)); // R3
  AST_ENTRY_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    trap_en |=> priv_q == PRIV_M && pp_q == $past(priv_q)); // R3
  AST_CAUSE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    trap_en |=> cause_irq_q == $past(trap_is_irq)); // R4
  AST_RETURN_POP: assert property (@(posedge clk) disable iff (!rst_n)
    mret_en |=> gie_q == $past(pie_q) && pie_q && priv_q == $past(pp_q)); // R7
endmodule

// File: rtl/mtrap_ctrl.sv
module mtrap_ctrl
  import mtrap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              mret_req,
  input  logic              irq_sw,
  input  logic              irq_tmr,
  input  logic              irq_ext,
  input  logic              csr_we,
  input  logic [11:0]       csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              redir_valid,
  output logic [XLEN-1:0]   redir_pc,
  output logic [1:0]        priv
);
  logic [NIRQ-1:0]   lines, ie, sel;
  logic              gie, irq_take, trap_en, trap_is_irq, mret_en;
  logic [3:0]        irq_code;
  logic [CODE_W-1:0] trap_code;
  logic [XLEN-1:0]   vec_base, epc;

  always_comb begin
    lines = '0;
    lines[IX_SW]  = irq_sw;
    lines[IX_TMR] = irq_tmr;
    lines[IX_EXT] = irq_ext;
  end

  mtrap_irq_arb u_arb (
    .clk(clk), .rst_n(rst_n), .pend(lines), .en(ie), .gie(gie),
    .take(irq_take), .code(irq_code), .sel(sel)
  );

  assign trap_en     = exc_req | irq_take;
  assign trap_is_irq = !exc_req;
  assign trap_code   = exc_req ? exc_code : CODE_W'(irq_code);
  assign mret_en     = mret_req & !trap_en;

  mtrap_csr_regs #(.XLEN(XLEN), .CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .trap_en(trap_en), .trap_is_irq(trap_is_irq), .trap_code(trap_code),
    .trap_pc(cur_pc), .mret_en(mret_en),
    .wr_en(csr_we), .addr(csr_addr), .wr_data(csr_wdata), .lines(lines),
    .rd_data(csr_rdata), .vec_base(vec_base), .epc(epc),
    .gie(gie), .ie(ie), .priv(priv)
  );

  assign redir_valid = trap_en | mret_en;
  assign redir_pc    = trap_en ? vec_base : epc;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (|sel) |-> gie); // R4
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    trap_en |-> redir_pc[1:0] == 2'b00); // R9
  AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_req && !exc_req && !(|sel)) |-> redir_valid && redir_pc == epc); // R7
endmodule

// File: tb/sim_mtrap_ctrl.sv
module sim_mtrap_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req = 1'b0;
  logic [4:0]  exc_code = '0;
  logic [31:0] cur_pc = '0;
  logic        mret_req = 1'b0;
  logic        irq_sw = 1'b0, irq_tmr = 1'b0, irq_ext = 1'b0;
  logic        csr_we = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        redir_valid;
  logic [31:0] redir_pc;
  logic [1:0]  priv;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  mtrap_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
    .cur_pc(cur_pc), .mret_req(mret_req), .irq_sw(irq_sw), .irq_tmr(irq_tmr),
    .irq_ext(irq_ext), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .redir_valid(redir_valid),
    .redir_pc(redir_pc), .priv(priv)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    csr_addr = a; #1; d = csr_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d; tick(); csr_we = 1'b0;
  endtask

  task automatic chk_csr(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d); chk(req, d, exp);
  endtask

  task automatic t_reset();
    chk("R1 priv", {30'd0, priv}, 32'd3);
    chk_csr("R1 status", 12'h300, 0);
    chk_csr("R1 ie", 12'h304, 0);
    chk_csr("R1 cause", 12'h342, 0);
    chk_csr("R1 epc", 12'h341, 0);
    chk_csr("R1 tvec", 12'h305, 0);
    chk_csr("R1 unmapped", 12'h7C0, 0);
  endtask

  task automatic t_csr_rw();
    wr(12'h305, 32'h0000_1003);
    chk_csr("R9 tvec low bits", 12'h305, 32'h0000_1000);
    wr(12'h341, 32'h0000_2468);
    chk_csr("R11 epc rw", 12'h341, 32'h0000_2468);
    wr(12'h304, 32'hFFFF_FFFF);
    chk_csr("R11 ie rw", 12'h304, 32'h0000_0888);
    wr(12'h304, 32'h0);
    wr(12'h300, 32'h0000_1000);
    chk_csr("R11 status pp illegal", 12'h300, 32'h0);
    wr(12'h342, 32'h8000_0005);
    chk_csr("R11 cause rw", 12'h342, 32'h8000_0005);
  endtask

  task automatic t_exception();
    wr(12'h300, 32'h0000_0008);
    exc_req = 1'b1; exc_code = 5'd2; cur_pc = 32'h400; #1;
    chk("R2 redir valid", {31'd0, redir_valid}, 1);
    chk("R2 redir pc", redir_pc, 32'h1000);
    tick(); exc_req = 1'b0;
    chk_csr("R2 epc", 12'h341, 32'h400);
    chk_csr("R2 cause", 12'h342, 32'd2);
    chk_csr("R3 status push", 12'h300, 32'h0000_1880);
    chk("R3 priv", {30'd0, priv}, 32'd3);
  endtask

  task automatic t_mret();
    mret_req = 1'b1; #1;
    chk("R7 redir valid", {31'd0, redir_valid}, 1);
    chk("R7 redir pc", redir_pc, 32'h400);
    tick(); mret_req = 1'b0;
    chk_csr("R7 status pop", 12'h300, 32'h0000_0088);
    chk("R7 priv M", {30'd0, priv}, 32'd3);
    // round trip through user mode
    wr(12'h300, 32'h0000_0080);
    mret_req = 1'b1; tick(); mret_req = 1'b0;
    chk("R7 priv to U", {30'd0, priv}, 32'd0);
    chk_csr("R7 status after U return", 12'h300, 32'h0000_0088);
    exc_req = 1'b1; exc_code = 5'd8; cur_pc = 32'h800; tick(); exc_req = 1'b0;
    chk("R3 priv back to M", {30'd0, priv}, 32'd3);
    chk_csr("R3 pp holds U", 12'h300, 32'h0000_0080);
  endtask

  task automatic t_irq_gating();
    wr(12'h304, 32'h0000_0888);
    wr(12'h300, 32'h0);
    irq_tmr = 1'b1; #1;
    chk("R4 no take, gie off", {31'd0, redir_valid}, 0);
    irq_tmr = 1'b0;
    wr(12'h304, 32'h0000_0808);
    wr(12'h300, 32'h0000_0008);
    irq_tmr = 1'b1; #1;
    chk("R4 no take, class off", {31'd0, redir_valid}, 0);
    irq_tmr = 1'b0;
    wr(12'h304, 32'h0000_0888);
    irq_tmr = 1'b1; cur_pc = 32'h900; #1;
    chk("R4 take timer", {31'd0, redir_valid}, 1);
    tick(); irq_tmr = 1'b0;
    chk_csr("R4 timer cause", 12'h342, 32'h8000_0007);
    chk_csr("R4 epc", 12'h341, 32'h900);
  endtask

  task automatic t_priority();
    wr(12'h300, 32'h0000_0008);
    irq_sw = 1'b1; irq_tmr = 1'b1; irq_ext = 1'b1;
    tick(); irq_sw = 1'b0; irq_tmr = 1'b0; irq_ext = 1'b0;
    chk_csr("R5 external first", 12'h342, 32'h8000_000B);
    wr(12'h300, 32'h0000_0008);
    irq_sw = 1'b1; irq_tmr = 1'b1;
    tick(); irq_sw = 1'b0; irq_tmr = 1'b0;
    chk_csr("R5 software before timer", 12'h342, 32'h8000_0003);
  endtask

  task automatic t_exc_vs_irq();
    wr(12'h300, 32'h0000_0008);
    irq_ext = 1'b1; exc_req = 1'b1; exc_code = 5'd5; cur_pc = 32'hA00;
    tick(); irq_ext = 1'b0; exc_req = 1'b0;
    chk_csr("R6 exception wins", 12'h342, 32'd5);
    // now gie=0: exception still taken
    exc_req = 1'b1; exc_code = 5'd13; #1;
    chk("R6 exc with gie off", {31'd0, redir_valid}, 1);
    tick(); exc_req = 1'b0;
    chk_csr("R6 cause", 12'h342, 32'd13);
  endtask

  task automatic t_conflict();
    csr_we = 1'b1; csr_addr = 12'h341; csr_wdata = 32'h55;
    exc_req = 1'b1; exc_code = 5'd4; cur_pc = 32'hC00;
    tick(); csr_we = 1'b0; exc_req = 1'b0;
    chk_csr("R10 trap beats epc write", 12'h341, 32'hC00);
    chk_csr("R10 trap status", 12'h300, 32'h0000_1800);
    wr(12'h300, 32'h0000_1880);
    csr_we = 1'b1; csr_addr = 12'h300; csr_wdata = 32'h0; mret_req = 1'b1;
    tick(); csr_we = 1'b0; mret_req = 1'b0;
    chk_csr("R10 return beats status write", 12'h300, 32'h0000_0088);
  endtask

  task automatic t_ip();
    wr(12'h300, 32'h0);
    irq_sw = 1'b1; irq_ext = 1'b1;
    chk_csr("R8 pending follows lines", 12'h344, 32'h0000_0808);
    wr(12'h344, 32'hFFFF_FFFF);
    chk_csr("R8 write ignored", 12'h344, 32'h0000_0808);
    irq_sw = 1'b0; irq_ext = 1'b0;
    chk_csr("R8 pending clears", 12'h344, 32'h0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_csr_rw();
    t_exception();
    t_mret();
    t_irq_gating();
    t_priority();
    t_exc_vs_irq();
    t_conflict();
    t_ip();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule